// File: doc/BRIEF.md
# Receive Free-Queue Selector

This block picks the free descriptor queue that supplies each receive buffer of a packet on one flow. A configuration port loads three packet-size thresholds, with one enable bit each, four queue numbers for the first buffer of a packet, and three queue numbers for the buffers that follow it. For every buffer request the caller gives the packet size in bytes, says whether this is the first buffer (start of packet) or a later one, and says whether the queue it last tried was empty. One clock later the block answers with a 16-bit queue number and the buffer's position in the packet.

For the first buffer, the size is compared with each enabled threshold, scaled to 32-byte units, from the lowest to the highest. The first threshold that the size does not exceed picks the matching queue. Later buffers take fixed queues chosen by their position, and every buffer from the fourth on shares one queue. When a request reports starvation, a mode bit decides whether the packet is dropped or the same allocation is retried without moving the position forward. While the channel is enabled the configuration is frozen.

Top module: `rx_freeq_sel`

## Requirements
- R1: A threshold field T stands for a byte limit of T*32. A packet of exactly T*32 bytes is at or below the limit, and a packet of T*32+1 bytes is above it.
- R2: With all three thresholds enabled and strictly increasing, a start-of-packet request takes first-buffer queue 0 if size <= limit 0, queue 1 if size <= limit 1, queue 2 if size <= limit 2, and queue 3 otherwise.
- R3: A threshold whose enable bit is clear takes no part. The enabled thresholds are checked from the lowest index up, the first one the size does not exceed selects the first-buffer queue with its own index, and a size above all of them selects queue 3.
- R4: When no enable bit is set, every start-of-packet request takes first-buffer queue 0, whatever its size.
- R5: A continuation request at buffer index 1 takes later-buffer queue A, at index 2 queue B, and at index 3 queue C.
- R6: `rsp_bufidx` is 0 for a start-of-packet request. It is one more than the index of the last buffer that was allocated without starvation for a continuation request, and it saturates at 3.
- R7: Each cycle with `req_valid` high is answered in the next cycle with `rsp_valid` high for one cycle. `rsp_valid` is low in every other cycle.
- R8: With control bit 3 clear, a starved request answers with `rsp_drop` high, and the index count is cleared to 0, so the next continuation request gets index 1.
- R9: With control bit 3 set, a starved request answers with `rsp_retry` high and leaves the index count unchanged, so a repeated continuation request gets the same index and queue.
- R10: `cfg_err` is high when two enabled thresholds that are consecutive among the enabled ones are not strictly increasing (equal values count as an error). While it is high, every start-of-packet request takes first-buffer queue 0.
- R11: Configuration writes that arrive while `chan_en` is high have no effect.
- R12: After reset, `rsp_valid`, `rsp_drop`, `rsp_retry` and `cfg_err` are low, and every configuration field is 0.
- R13: Configuration addresses, with data in the low bits: 0 = control (bits 2..0 are the enables of thresholds 2..0, bit 3 is retry mode), 1..3 = thresholds 0..2, 4..7 = first-buffer queues 0..3, 8..10 = later-buffer queues A..C. Writes to addresses 11..15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chan_en | input | 1 | Channel enabled; freezes the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | W (16) | Configuration write data |
| req_valid | input | 1 | Buffer request |
| req_sop | input | 1 | Request is for the first buffer of a packet |
| req_size | input | PKT_W (20) | Packet size in bytes |
| req_starve | input | 1 | The queue for this request was empty |
| rsp_valid | output | 1 | Response pulse, one cycle after a request |
| rsp_qnum | output | W (16) | Selected free queue number |
| rsp_bufidx | output | 2 | Buffer position in the packet, saturating at 3 |
| rsp_drop | output | 1 | Starved request, packet dropped |
| rsp_retry | output | 1 | Starved request, allocation to be retried |
| cfg_err | output | 1 | Enabled thresholds are not strictly increasing |

## Verification
Sizes placed exactly on each scaled limit and one byte past it separate correct 32-byte scaling and inclusive comparison from off-by-one or unscaled compares. Sparse enable patterns (only thresholds 0 and 2, only threshold 1, none) separate real skipping of disabled thresholds from plain position-based priority. Runs of continuation requests longer than three buffers show the saturation at 3 and the shared queue C. The same starved continuation is run in both modes to tell drop-and-clear apart from hold-and-retry. Equal and descending threshold pairs drive the ordering error, and writes made while the channel is enabled are checked later through the queue they would have changed.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_THR0  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SOPQ0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CONTQ = 4'd8;
  localparam int N_THR  = 3;
  localparam int N_SOPQ = 4;
  localparam int N_CONT = 3;
  localparam int UNIT_SH = 5;
endpackage

// File: rtl/rxq_cfg_regs.sv
module rxq_cfg_regs
  import rxq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chan_en,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [W-1:0]           cfg_wdata,
  output logic [3:0]             ctrl,
  output logic [N_THR-1:0][W-1:0]  thr,
  output logic [N_SOPQ-1:0][W-1:0] sopq,
  output logic [N_CONT-1:0][W-1:0] contq
);
  logic wr_ok;
  assign wr_ok = cfg_we && !chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_ok && cfg_addr == A_CTRL) ctrl <= cfg_wdata[3:0];
  end

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr[g] <= '0;
      else if (wr_ok && cfg_addr == A_THR0 + ADDR_W'(g)) thr[g] <= cfg_wdata;
    end
  end

  for (genvar g = 0; g < N_SOPQ; g++) begin : g_sopq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sopq[g] <= '0;
      else if (wr_ok && cfg_addr == A_SOPQ0 + ADDR_W'(g)) sopq[g] <= cfg_wdata;
    end
  end

  for (genvar g = 0; g < N_CONT; g++) begin : g_contq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) contq[g] <= '0;
      else if (wr_ok && cfg_addr == A_CONTQ + ADDR_W'(g)) contq[g] <= cfg_wdata;
    end
  end

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> ($stable(ctrl) && $stable(thr) && $stable(sopq) && $stable(contq)));
endmodule

// File: rtl/rxq_sop_pick.sv
module rxq_sop_pick
  import rxq_pkg::*;
#(
  parameter int W     = 16,
  parameter int PKT_W = 20
) (
  input  logic [PKT_W-1:0]         size,
  input  logic [N_THR-1:0]         thr_en,
  input  logic [N_THR-1:0][W-1:0]  thr,
  input  logic [N_SOPQ-1:0][W-1:0] sopq,
  output logic [W-1:0]             sop_qnum,
  output logic                     order_err
);
  localparam int LW = W + UNIT_SH;
  localparam int CW = (PKT_W > LW) ? PKT_W : LW;

  logic [N_THR-1:0] hit;
  for (genvar g = 0; g < N_THR; g++) begin : g_cmp
    logic [CW-1:0] lim;
    assign lim    = CW'({thr[g], {UNIT_SH{1'b0}}});
    assign hit[g] = thr_en[g] && (CW'(size) <= lim);
  end

  logic e01, e12, e02;
  assign e01 = thr_en[0] && thr_en[1] && !(thr[1] > thr[0]);
  assign e12 = thr_en[1] && thr_en[2] && !(thr[2] > thr[1]);
  assign e02 = thr_en[0] && !thr_en[1] && thr_en[2] && !(thr[2] > thr[0]);
  assign order_err = e01 || e12 || e02;

  logic [1:0] sel;
  always_comb begin
    if (order_err || thr_en == '0) sel = 2'd0;
    else if (hit[0])               sel = 2'd0;
    else if (hit[1])               sel = 2'd1;
    else if (hit[2])               sel = 2'd2;
    else                           sel = 2'd3;
  end
  assign sop_qnum = sopq[sel];
endmodule

// File: rtl/rxq_buf_track.sv
module rxq_buf_track
  import rxq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_sop,
  input  logic                     req_starve,
  input  logic                     retry_mode,
  input  logic [W-1:0]             sop_qnum,
  input  logic [N_CONT-1:0][W-1:0] contq,
  output logic                     rsp_valid,
  output logic [W-1:0]             rsp_qnum,
  output logic [1:0]               rsp_bufidx,
  output logic                     rsp_drop,
  output logic                     rsp_retry
);
  logic [1:0]   last_idx, last_nxt, req_idx;
  logic [W-1:0] q_sel;

  always_comb begin
    if (req_sop)             req_idx = 2'd0;
    else if (last_idx == 2'd3) req_idx = 2'd3;
    else                     req_idx = last_idx + 2'd1;
    case (req_idx)
      2'd0:    q_sel = sop_qnum;
      2'd1:    q_sel = contq[0];
      2'd2:    q_sel = contq[1];
      default: q_sel = contq[2];
    endcase
    last_nxt = last_idx;
    if (req_valid) begin
      if (!req_starve)     last_nxt = req_idx;
      else if (!retry_mode) last_nxt = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_idx <= '0;
    else        last_idx <= last_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_drop  <= 1'b0;
      rsp_retry <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_drop  <= req_valid && req_starve && !retry_mode;
      rsp_retry <= req_valid && req_starve && retry_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_qnum   <= '0;
      rsp_bufidx <= '0;
    end else if (req_valid) begin
      rsp_qnum   <= q_sel;
      rsp_bufidx <= req_idx;
    end
  end

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R7
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R6
  sop_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sop) |=> (rsp_bufidx == 2'd0));
  // R8
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_drop |-> (rsp_valid && !rsp_retry));
  // R8
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_drop && req_valid && !req_sop) |=> (rsp_bufidx == 2'd1));
  // R9
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_retry && req_valid && !req_sop) |=> (rsp_bufidx == $past(rsp_bufidx)));
endmodule

// File: rtl/rx_freeq_sel.sv
module rx_freeq_sel
  import rxq_pkg::*;
#(
  parameter int W     = 16,
  parameter int PKT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [W-1:0]      cfg_wdata,
  input  logic              req_valid,
  input  logic              req_sop,
  input  logic [PKT_W-1:0]  req_size,
  input  logic              req_starve,
  output logic              rsp_valid,
  output logic [W-1:0]      rsp_qnum,
  output logic [1:0]        rsp_bufidx,
  output logic              rsp_drop,
  output logic              rsp_retry,
  output logic              cfg_err
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [3:0]               ctrl;
  logic [N_THR-1:0][W-1:0]  thr;
  logic [N_SOPQ-1:0][W-1:0] sopq;
  logic [N_CONT-1:0][W-1:0] contq;
  logic [W-1:0]             sop_qnum;

  rxq_cfg_regs #(.W(W)) u_cfg (
    .clk, .rst_n(rst_int_n), .chan_en, .cfg_we, .cfg_addr, .cfg_wdata,
    .ctrl, .thr, .sopq, .contq
  );

  rxq_sop_pick #(.W(W), .PKT_W(PKT_W)) u_pick (
    .size(req_size), .thr_en(ctrl[2:0]), .thr, .sopq,
    .sop_qnum, .order_err(cfg_err)
  );

  rxq_buf_track #(.W(W)) u_track (
    .clk, .rst_n(rst_int_n), .req_valid, .req_sop, .req_starve,
    .retry_mode(ctrl[3]), .sop_qnum, .contq,
    .rsp_valid, .rsp_qnum, .rsp_bufidx, .rsp_drop, .rsp_retry
  );

  // R10
  err_fallback_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_sop && cfg_err) |=> (rsp_qnum == $past(sopq[0])));
  // R4
  no_thr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_sop && ctrl[2:0] == 3'b000) |=> (rsp_qnum == $past(sopq[0])));
endmodule

// File: tb/rx_freeq_sel_tb.sv
`timescale 1ns/1ps
module rx_freeq_sel_tb;
  localparam int W = 16;
  localparam int PKT_W = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, chan_en, cfg_we, req_valid, req_sop, req_starve;
  logic [3:0] cfg_addr;
  logic [W-1:0] cfg_wdata;
  logic [PKT_W-1:0] req_size;
  logic rsp_valid, rsp_drop, rsp_retry, cfg_err;
  logic [W-1:0] rsp_qnum;
  logic [1:0] rsp_bufidx;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  rx_freeq_sel #(.W(W), .PKT_W(PKT_W)) u_dut (
    .clk, .rst_n, .chan_en, .cfg_we, .cfg_addr, .cfg_wdata,
    .req_valid, .req_sop, .req_size, .req_starve,
    .rsp_valid, .rsp_qnum, .rsp_bufidx, .rsp_drop, .rsp_retry, .cfg_err
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One request; response checked at the next falling edge.
  task automatic rq(input string tag, input logic sop, input int size, input logic starve,
                    input logic [W-1:0] eq, input logic [1:0] eidx,
                    input logic edrop, input logic eretry);
    @(negedge clk);
    req_valid = 1'b1; req_sop = sop; req_size = PKT_W'(size); req_starve = starve;
    @(negedge clk);
    req_valid = 1'b0; req_starve = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " qnum"}, 32'(rsp_qnum), 32'(eq));
    chk({tag, " idx"}, 32'(rsp_bufidx), 32'(eidx));
    chk({tag, " drop"}, 32'(rsp_drop), 32'(edrop));
    chk({tag, " retry"}, 32'(rsp_retry), 32'(eretry));
  endtask

  task automatic load_queues();
    for (int i = 0; i < 4; i++) wr(4'(4 + i), W'(16'h0100 + i));
    for (int i = 0; i < 3; i++) wr(4'(8 + i), W'(16'h0201 + i));
  endtask

  task automatic set_thr(input int t0, input int t1, input int t2, input logic [3:0] c);
    wr(4'd1, W'(t0)); wr(4'd2, W'(t1)); wr(4'd3, W'(t2)); wr(4'd0, W'(c));
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R12 rsp_valid", 32'(rsp_valid), 0);
    chk("R12 cfg_err", 32'(cfg_err), 0);
    chk("R12 drop", 32'(rsp_drop), 0);
    rq("R12 zero cfg", 1'b1, 5000, 1'b0, 16'h0000, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic test_no_thr();
    load_queues();
    rq("R4 small", 1'b1, 5, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    rq("R4 large", 1'b1, 500000, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic test_scale();
    set_thr(2, 4, 8, 4'b0111);
    chk("R2 no err", 32'(cfg_err), 0);
    rq("R2 zero", 1'b1, 0, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    rq("R1 at lim0", 1'b1, 64, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    rq("R1 past lim0", 1'b1, 65, 1'b0, 16'h0101, 2'd0, 1'b0, 1'b0);
    rq("R2 at lim1", 1'b1, 128, 1'b0, 16'h0101, 2'd0, 1'b0, 1'b0);
    rq("R2 past lim1", 1'b1, 129, 1'b0, 16'h0102, 2'd0, 1'b0, 1'b0);
    rq("R2 at lim2", 1'b1, 256, 1'b0, 16'h0102, 2'd0, 1'b0, 1'b0);
    rq("R2 above all", 1'b1, 257, 1'b0, 16'h0103, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic test_skip();
    wr(4'd0, 16'h0005);
    rq("R3 en02 mid", 1'b1, 100, 1'b0, 16'h0102, 2'd0, 1'b0, 1'b0);
    rq("R3 en02 low", 1'b1, 64, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    wr(4'd0, 16'h0002);
    rq("R3 en1 low", 1'b1, 10, 1'b0, 16'h0101, 2'd0, 1'b0, 1'b0);
    rq("R3 en1 high", 1'b1, 200, 1'b0, 16'h0103, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic test_cont();
    wr(4'd0, 16'h0007);
    rq("R6 sop", 1'b1, 10, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    rq("R5 second", 1'b0, 10, 1'b0, 16'h0201, 2'd1, 1'b0, 1'b0);
    rq("R5 third", 1'b0, 10, 1'b0, 16'h0202, 2'd2, 1'b0, 1'b0);
    rq("R5 fourth", 1'b0, 10, 1'b0, 16'h0203, 2'd3, 1'b0, 1'b0);
    rq("R6 saturate", 1'b0, 10, 1'b0, 16'h0203, 2'd3, 1'b0, 1'b0);
    rq("R6 new sop", 1'b1, 300, 1'b0, 16'h0103, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic test_valid();
    rq("R7 pulse", 1'b1, 10, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 idle low", 32'(rsp_valid), 0);
  endtask

  task automatic test_drop();
    wr(4'd0, 16'h0007);
    rq("R8 sop", 1'b1, 10, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    rq("R8 cont", 1'b0, 10, 1'b0, 16'h0201, 2'd1, 1'b0, 1'b0);
    rq("R8 starve", 1'b0, 10, 1'b1, 16'h0202, 2'd2, 1'b1, 1'b0);
    rq("R8 after drop", 1'b0, 10, 1'b0, 16'h0201, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic test_retry();
    wr(4'd0, 16'h000F);
    rq("R9 sop", 1'b1, 10, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    rq("R9 cont", 1'b0, 10, 1'b0, 16'h0201, 2'd1, 1'b0, 1'b0);
    rq("R9 starve1", 1'b0, 10, 1'b1, 16'h0202, 2'd2, 1'b0, 1'b1);
    rq("R9 starve2", 1'b0, 10, 1'b1, 16'h0202, 2'd2, 1'b0, 1'b1);
    rq("R9 success", 1'b0, 10, 1'b0, 16'h0202, 2'd2, 1'b0, 1'b0);
    rq("R9 advance", 1'b0, 10, 1'b0, 16'h0203, 2'd3, 1'b0, 1'b0);
  endtask

  task automatic test_err();
    set_thr(4, 4, 8, 4'b0011);
    chk("R10 equal err", 32'(cfg_err), 1);
    rq("R10 fallback small", 1'b1, 200, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    rq("R10 fallback big", 1'b1, 900, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    set_thr(4, 4, 3, 4'b0101);
    chk("R10 skip pair err", 32'(cfg_err), 1);
    wr(4'd0, 16'h0004);
    chk("R10 single ok", 32'(cfg_err), 0);
    rq("R10 single sel", 1'b1, 10, 1'b0, 16'h0102, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic test_lock();
    wr(4'd0, 16'h0000);
    @(negedge clk); chan_en = 1'b1;
    wr(4'd4, 16'hBEEF);
    wr(4'd0, 16'h0008);
    @(negedge clk); chan_en = 1'b0;
    rq("R11 queue kept", 1'b1, 10, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
    rq("R11 mode kept", 1'b1, 10, 1'b1, 16'h0100, 2'd0, 1'b1, 1'b0);
    wr(4'd12, 16'h0007);
    rq("R13 bad addr", 1'b1, 300, 1'b0, 16'h0100, 2'd0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_sop = 1'b0; req_size = '0; req_starve = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_no_thr();
    test_scale();
    test_skip();
    test_cont();
    test_valid();
    test_drop();
    test_retry();
    test_err();
    test_lock();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule